// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block translates a 14-bit virtual address into a 12-bit physical address using a page table held in memory. Pages are 64 bytes, so the low 6 address bits pass through unchanged. The upper 8 bits select one of 256 table entries.

When a request is accepted, the block latches the virtual address, the access kind (read or write) and the privilege level. It also latches the table base. It then forms the entry address and reads the entry over a plain request/acknowledge port. Next it tests the entry's presence and permission bits. Finally it returns either a physical address or a fault cause.

Requests and responses are valid/ready streams:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high only while the block is idle, so only one translation is in flight.
- A response stays on the output, unchanged, until the consumer raises `rsp_ready`. That back-pressure holds the block busy.

Top module: `xlat_unit`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy`, `rsp_valid` and `mem_req` are 0.
- R2: The entry read address is the latched table base plus twice the virtual page number (`vaddr[13:6]`), taken modulo 4096.
- R3: `req_ready` is high only when no translation is in progress. `req_valid` offered during a translation is ignored. The result and the fetched entry belong to the request that was accepted.
- R4: Entry layout: bits [5:0] hold the physical page number, bit 6 is present, bit 7 permits reads, bit 8 permits writes, and bit 9 marks the page supervisor-only. On success, `rsp_paddr` is {entry[5:0], vaddr[5:0]}.
- R5: If the present bit is 0, `rsp_fault` is 2'b01 and `rsp_paddr` is 0, whatever the permission bits are.
- R6: A present entry gives `rsp_fault` 2'b10 and `rsp_paddr` 0 in any of these cases:
  - the page is supervisor-only and the access is user mode;
  - the access is a read and bit 7 is 0;
  - the access is a write and bit 8 is 0.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold. `busy` stays high until the response is taken.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen. Each accepted request makes exactly one entry read.
- R9: A translation that passes every check returns `rsp_fault` 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 12 | Page table base byte address, latched at accept |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_vaddr | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes result |
| rsp_paddr | output | 12 | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 permission |
| busy | output | 1 | Translation in progress |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 12 | Entry byte address |
| mem_ack | input | 1 | Entry data valid this cycle |
| mem_rdata | input | 10 | Page table entry |

## Verification
The bench builds the block with its default split: 14-bit virtual addresses, 12-bit physical addresses, 64-byte pages and 10-bit entries. That keeps the page table at 256 entries, so every virtual page can be swept under all four read/write and user/supervisor combinations. A synthetic table mixes absent pages and every permission pattern.

The sweep is repeated twice:
- once with a zero base and an immediate acknowledge;
- once with a base near the top of memory, where entry addresses wrap, and with a delayed acknowledge.

Response back-pressure and requests offered while the block is busy are mixed into the sweep.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } xl_state_t;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PERM   = 2'b10
  } xl_fault_t;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int PA_W      = 12,
  parameter int VPN_W     = 8,
  parameter int PTE_BYTES = 2
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [PA_W-1:0] scaled;

  always_comb begin
    scaled = PA_W'(vpn_i) * PA_W'(PTE_BYTES);
    addr_o = base_i + scaled;
  end
endmodule

// File: rtl/xlat_pte_check.sv
module xlat_pte_check
  import xlat_pkg::*;
#(
  parameter int PPN_W = 6,
  parameter int OFF_W = 6
) (
  input  logic [PPN_W+3:0]       pte_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic                   is_write_i,
  input  logic                   is_super_i,
  output logic [PPN_W+OFF_W-1:0] paddr_o,
  output xl_fault_t              fault_o
);
  localparam int PRESENT_B = PPN_W;
  localparam int RD_B      = PPN_W + 1;
  localparam int WR_B      = PPN_W + 2;
  localparam int SUP_B     = PPN_W + 3;

  logic denied;

  always_comb begin
    denied = (pte_i[SUP_B] && !is_super_i) ||
             (!is_write_i && !pte_i[RD_B]) ||
             (is_write_i && !pte_i[WR_B]);

    // Absence outranks any permission problem.
    if (!pte_i[PRESENT_B]) begin
      fault_o = FLT_ABSENT;
    end else if (denied) begin
      fault_o = FLT_PERM;
    end else begin
      fault_o = FLT_NONE;
    end

    paddr_o = (fault_o == FLT_NONE) ? {pte_i[PPN_W-1:0], off_i} : '0;
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int PA_W      = 12,
  parameter int OFF_W     = 6,
  parameter int PTE_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PA_W-1:0]        pt_base,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic                   req_super,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PA_W-1:0]        rsp_paddr,
  output logic [1:0]             rsp_fault,
  output logic                   busy,
  output logic                   mem_req,
  output logic [PA_W-1:0]        mem_addr,
  input  logic                   mem_ack,
  input  logic [PA_W-OFF_W+3:0]  mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  xl_state_t       state;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            sup_q;
  logic [PA_W-1:0] base_q;
  logic [PA_W-1:0] paddr_q;
  xl_fault_t       fault_q;

  logic [PA_W-1:0] chk_paddr;
  xl_fault_t       chk_fault;

  xlat_addr_gen #(
    .PA_W      (PA_W),
    .VPN_W     (VPN_W),
    .PTE_BYTES (PTE_BYTES)
  ) u_addr (
    .base_i (base_q),
    .vpn_i  (va_q[VA_W-1:OFF_W]),
    .addr_o (mem_addr)
  );

  xlat_pte_check #(
    .PPN_W (PPN_W),
    .OFF_W (OFF_W)
  ) u_check (
    .pte_i      (mem_rdata),
    .off_i      (va_q[OFF_W-1:0]),
    .is_write_i (wr_q),
    .is_super_i (sup_q),
    .paddr_o    (chk_paddr),
    .fault_o    (chk_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      sup_q   <= 1'b0;
      base_q  <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            wr_q   <= req_write;
            sup_q  <= req_super;
            base_q <= pt_base;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            paddr_q <= chk_paddr;
            fault_q <= chk_fault;
            state   <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    busy      = (state != ST_IDLE);
    mem_req   = (state == ST_FETCH);
    rsp_valid = (state == ST_RESP);
    rsp_paddr = paddr_q;
    rsp_fault = fault_q;
  end
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            busy,
  input logic            mem_req,
  input logic [PA_W-1:0] mem_addr,
  input logic            mem_ack
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (req_valid && req_ready) begin
      off_q <= req_vaddr[OFF_W-1:0];
    end
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));

  p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && busy && $stable(rsp_paddr) && $stable(rsp_fault)));

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

  p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'b11));

  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> (rsp_paddr[OFF_W-1:0] == off_q));
endmodule

bind xlat_unit xlat_unit_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (OFF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/sim_xlat_unit.sv
`timescale 1ns/1ps
module sim_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pt_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [11:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        busy;
  logic        mem_req;
  logic [11:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [9:0]  mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  cur_vpn = '0;
  logic [11:0] cur_base = '0;
  int          lat = 0;
  int          wait_cnt = 0;
  int          reads = 0;

  always #5 clk = ~clk;

  xlat_unit u0 (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Synthetic page table: [5:0] ppn, 6 present, 7 read, 8 write, 9 supervisor-only
  function automatic logic [9:0] pte_of(input logic [7:0] v);
    logic [5:0] ppn;
    logic pres, rd, wr, sup;
    ppn  = 6'((v * 5 + 3) & 63);
    pres = (v % 7) != 3;
    rd   = v[0] | v[3];
    wr   = v[1];
    sup  = v[2];
    if (v == 8'h00) begin ppn = 6'h28; rd = 1; wr = 1; sup = 0; pres = 1; end
    if (v == 8'h0F) begin ppn = 6'h0D; rd = 1; wr = 1; sup = 0; pres = 1; end
    return {sup, wr, rd, pres, ppn};
  endfunction

  // Memory model, driven away from the active edge
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        reads++;
        chk(mem_addr == 12'(cur_base + 12'(cur_vpn) * 12'd2), "R2 entry address",
            32'(mem_addr), 32'(12'(cur_base + 12'(cur_vpn) * 12'd2)));
        mem_rdata = pte_of(cur_vpn);
        mem_ack = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic translate(input logic [7:0] vpn, input logic [5:0] off,
                           input bit wr, input bit sup, input int hold,
                           input bit spam);
    logic [9:0]  e;
    logic [1:0]  exp_f;
    logic [11:0] exp_pa;
    bit denied;
    e = pte_of(vpn);
    denied = (e[9] && !sup) || (!wr && !e[7]) || (wr && !e[8]);
    if (!e[6]) exp_f = 2'b01;
    else if (denied) exp_f = 2'b10;
    else exp_f = 2'b00;
    exp_pa = (exp_f == 2'b00) ? {e[5:0], off} : 12'h000;

    @(negedge clk);
    cur_vpn = vpn;
    cur_base = pt_base;
    reads = 0;
    req_vaddr = {vpn, off};
    req_write = wr;
    req_super = sup;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (spam) begin
      // R3: offer a different request while busy; it must be ignored
      req_vaddr = ~{vpn, off};
      req_write = ~wr;
      chk(!req_ready && busy, "R3 not ready while busy",
          32'({req_ready, busy}), 32'b01);
    end else begin
      req_valid = 1'b0;
    end
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      chk(rsp_valid && busy && rsp_paddr == exp_pa && rsp_fault == exp_f,
          "R7 held response", 32'({rsp_valid, busy, rsp_fault, rsp_paddr}),
          32'({2'b11, exp_f, exp_pa}));
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (exp_f == 2'b01)
      chk(rsp_fault == exp_f && rsp_paddr == exp_pa, "R5 not present",
          32'({rsp_fault, rsp_paddr}), 32'({exp_f, exp_pa}));
    else if (exp_f == 2'b10)
      chk(rsp_fault == exp_f && rsp_paddr == exp_pa, "R6 permission",
          32'({rsp_fault, rsp_paddr}), 32'({exp_f, exp_pa}));
    else
      chk(rsp_fault == exp_f && rsp_paddr == exp_pa, "R4 R9 translated",
          32'({rsp_fault, rsp_paddr}), 32'({exp_f, exp_pa}));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !busy && !rsp_valid && reads == 1, "R8 R3 one read, idle",
        32'({req_ready, busy, rsp_valid, 8'(reads)}), 32'({3'b100, 8'd1}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !rsp_valid && !mem_req, "R1 reset state",
        32'({req_ready, busy, rsp_valid, mem_req}), 32'b1000);
    for (int pass = 0; pass < 2; pass++) begin
      pt_base = (pass == 0) ? 12'h000 : 12'hF80;
      lat = (pass == 0) ? 0 : 2;
      for (int v = 0; v < 256; v++) begin
        for (int a = 0; a < 4; a++) begin
          translate(8'(v), 6'((v * 11 + a * 17 + pass * 5) & 63), a[0], a[1],
                    (v % 5 == 0) ? 2 : 0, (v % 3 == 0));
        end
      end
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule